// File: doc/BRIEF.md
# Dual-Context Program Counter

This unit holds the fetch address of a core that can run code from three places: a small register memory, a lookup RAM, and a large shared memory. The region the program counter sits in sets the execution context. The context in turn sets two things. It picks the size of a sequential step, which is one word in the two local memories and four bytes in the shared memory. It also sets how every relative branch offset is scaled, so that one binary encoding behaves the same wherever the code runs.

Each cycle the core presents one decoded operation for the instruction at the current PC. The operation is one of: sequential advance, short relative branch, long relative branch, register-relative branch, absolute branch, or hardware repeat setup. The unit registers the next PC and drives a fetch-source select. It raises a one-cycle refill request for the shared-memory fetch path whenever the flow of control jumps into that memory.

Repeat blocks in the local memories loop back with no overhead. In shared memory the loop-back is a forced branch taken while the last instruction of the block executes, and it costs a refill on every pass.

Top module: `pc_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, the PC is set to 0x00400 and `refill_o` is cleared.
- R2: `src_o` reflects the current PC region: 0 for 0x00000–0x001FF (register memory), 1 for 0x00200–0x003FF (lookup RAM), 2 for 0x00400–0xFFFFF (shared memory).
- R3: Op code 0 (and the unused codes 6 and 7) advances the PC by 1 in register/lookup context and by 4 in shared context.
- R4: Op code 1 takes the 9-bit signed `short_off_i`. The target is the following instruction's address plus the sign-extended field in register/lookup context, or plus that field shifted left by two in shared context.
- R5: Op code 2 takes the 20-bit signed byte offset `long_off_i`. It is added unchanged in shared context and arithmetically shifted right by two in register/lookup context, in both cases relative to the following instruction's address.
- R6: Op code 3 adds `reg_off_i` to the following instruction's address: unscaled in register/lookup context, shifted left by two in shared context.
- R7: Op code 4 loads the PC with `abs_tgt_i`.
- R8: Op code 5 advances like op 0 and arms a repeat block. The block starts at the next instruction and spans `rep_len_i` instructions, for `rep_cnt_i` passes in total. In register/lookup context, when the block's last instruction executes with op 0 and passes remain, the next PC is the block start and `refill_o` stays low.
- R9: The same loop-back in shared context raises `refill_o` for the cycle after the jump.
- R10: After the final pass the last instruction falls through sequentially. A block with `rep_len_i`=0 or `rep_cnt_i`≤1 never loops.
- R11: Any taken branch (op 1 to 4) cancels an armed repeat block.
- R12: `refill_o` is high for exactly the cycle after any change of flow (branch or repeat loop-back) whose target is at or above 0x00400. It is low after a sequential advance.
- R13: While `stall_i` is high, the PC and the repeat state hold and `refill_o` is low.
- R14: All address arithmetic wraps modulo 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall_i | input | 1 | Hold the PC this cycle |
| op_i | input | 3 | Decoded flow operation for the instruction at the PC |
| short_off_i | input | 9 | Signed short relative offset |
| long_off_i | input | 20 | Signed long relative byte offset |
| reg_off_i | input | 20 | Offset from a data register |
| abs_tgt_i | input | 20 | Absolute branch target |
| rep_len_i | input | 9 | Repeat block length in instructions |
| rep_cnt_i | input | 9 | Repeat pass count |
| pc_o | output | 20 | Current program counter |
| src_o | output | 2 | Fetch source select |
| refill_o | output | 1 | Shared-memory fetch refill request |

## Verification
The hardest situation to reach is a repeat block whose pass count runs out, or that is cancelled midway, while its last address is hit with exactly the right operation. Random traffic seldom lines up a setup, the right number of sequential steps and the block end. Directed sequences therefore arm blocks of one to three instructions in both the local and shared regions, walk them to expiry, and cancel one with a zero-offset branch. Random traffic then adds short blocks after frequent setups, with stalls mixed in.

// File: rtl/pcu_pkg.sv
// Shared types and operation codes for the dual-context program counter.
package pcu_pkg;
    typedef enum logic [1:0] {
        CTX_REG = 2'd0,
        CTX_LUT = 2'd1,
        CTX_SHR = 2'd2
    } ctx_e;

    localparam logic [2:0] OP_SEQ    = 3'd0;
    localparam logic [2:0] OP_SHORT  = 3'd1;
    localparam logic [2:0] OP_LONG   = 3'd2;
    localparam logic [2:0] OP_REGREL = 3'd3;
    localparam logic [2:0] OP_ABS    = 3'd4;
    localparam logic [2:0] OP_REP    = 3'd5;
endpackage

// File: rtl/pcu_region.sv
// Maps an execution address to its context.
// Assumes REG_END <= LUT_END; everything at or above LUT_END is shared memory.
module pcu_region
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter logic [ADDR_W-1:0] REG_END = 20'h00200,
    parameter logic [ADDR_W-1:0] LUT_END = 20'h00400
) (
    input  logic [ADDR_W-1:0] addr_i,
    output ctx_e              ctx_o
);
    // Region compare against the two boundaries.
    always_comb begin
        if (addr_i < REG_END)      ctx_o = CTX_REG;
        else if (addr_i < LUT_END) ctx_o = CTX_LUT;
        else                       ctx_o = CTX_SHR;
    end
endmodule

// File: rtl/pcu_target.sv
// Computes the sequential address and every relative branch target for the
// instruction at pc_i, with offsets scaled by the current context.
// Assumes SHORT_W < ADDR_W and ADDR_W > 2.
module pcu_target
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned SHORT_W = 9,
    parameter int unsigned LONG_W  = 20
) (
    input  logic [ADDR_W-1:0]  pc_i,
    input  ctx_e               ctx_i,
    input  logic [SHORT_W-1:0] short_off_i,
    input  logic [LONG_W-1:0]  long_off_i,
    input  logic [ADDR_W-1:0]  reg_off_i,
    output logic [ADDR_W-1:0]  seq_o,
    output logic [ADDR_W-1:0]  short_o,
    output logic [ADDR_W-1:0]  long_o,
    output logic [ADDR_W-1:0]  regrel_o
);
    localparam int unsigned SEXT_W = ADDR_W - SHORT_W;

    logic              in_shr;
    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] short_ext;
    logic [ADDR_W-1:0] long_ext;
    logic [ADDR_W-1:0] short_scl;
    logic [ADDR_W-1:0] long_scl;
    logic [ADDR_W-1:0] reg_scl;

    // Long offset brought to address width; the variant depends on widths.
    generate
        if (LONG_W < ADDR_W) begin : g_long_sext
            assign long_ext = {{(ADDR_W-LONG_W){long_off_i[LONG_W-1]}}, long_off_i};
        end else begin : g_long_trunc
            assign long_ext = long_off_i[ADDR_W-1:0];
        end
    endgenerate

    // Context-dependent scaling and target sums (all wrap at ADDR_W bits).
    always_comb begin
        in_shr    = (ctx_i == CTX_SHR);
        step      = in_shr ? ADDR_W'(4) : ADDR_W'(1);
        short_ext = {{SEXT_W{short_off_i[SHORT_W-1]}}, short_off_i};
        short_scl = in_shr ? (short_ext << 2) : short_ext;
        long_scl  = in_shr ? long_ext : {{2{long_ext[ADDR_W-1]}}, long_ext[ADDR_W-1:2]};
        reg_scl   = in_shr ? (reg_off_i << 2) : reg_off_i;
        seq_o     = pc_i + step;
        short_o   = seq_o + short_scl;
        long_o    = seq_o + long_scl;
        regrel_o  = seq_o + reg_scl;
    end
endmodule

// File: rtl/pcu_repeat.sv
// Repeat-block tracker: stores block start, last address and remaining
// passes; flags a loop-back when the last instruction executes sequentially.
// Assumes adv_i is low while the core is stalled.
module pcu_repeat
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W = 20,
    parameter int unsigned LEN_W  = 9,
    parameter int unsigned CNT_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv_i,
    input  logic [2:0]        op_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] seq_i,
    input  logic              shr_i,
    input  logic [LEN_W-1:0]  len_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              hit_o,
    output logic [ADDR_W-1:0] start_o
);
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] last_q;
    logic [CNT_W-1:0]  rem_q;
    logic [ADDR_W-1:0] span;
    logic              taken;
    logic              seq_class;

    // Decode of the op classes and the byte/word span of a new block.
    always_comb begin
        taken     = (op_i == OP_SHORT) || (op_i == OP_LONG) ||
                    (op_i == OP_REGREL) || (op_i == OP_ABS);
        seq_class = !taken && (op_i != OP_REP);
        span      = ADDR_W'(LEN_W'(len_i - LEN_W'(1)));
        if (shr_i) span = span << 2;
        hit_o     = (rem_q != '0) && (pc_i == last_q) && seq_class;
        start_o   = start_q;
    end

    // Block state: arm on setup, clear on taken branch, count down on loop-back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= '0;
            last_q  <= '0;
            rem_q   <= '0;
        end else if (adv_i) begin
            if (op_i == OP_REP) begin
                start_q <= seq_i;
                last_q  <= seq_i + span;
                rem_q   <= (len_i != '0 && cnt_i > CNT_W'(1)) ? cnt_i - CNT_W'(1) : '0;
            end else if (taken) begin
                rem_q <= '0;
            end else if (hit_o) begin
                rem_q <= rem_q - CNT_W'(1);
            end
        end
    end

    AST_REM_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && hit_o |=> rem_q == $past(rem_q) - CNT_W'(1)); // R10
    AST_BRANCH_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        adv_i && taken |=> rem_q == '0); // R11
    AST_STALL_KEEPS_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_i |=> $stable(rem_q) && $stable(last_q)); // R13
endmodule

// File: rtl/pc_unit.sv
// Dual-context program counter. Selects the next fetch address from the
// decoded flow operation, scaling steps and offsets by the region of the
// current PC, and requests a shared-memory refill after jumps into it.
// Assumes op_i describes the instruction at pc_o in the same cycle.
module pc_unit
    import pcu_pkg::*;
#(
    parameter int unsigned ADDR_W  = 20,
    parameter int unsigned SHORT_W = 9,
    parameter int unsigned LONG_W  = 20,
    parameter int unsigned LEN_W   = 9,
    parameter int unsigned CNT_W   = 9,
    parameter logic [ADDR_W-1:0] REG_END  = 20'h00200,
    parameter logic [ADDR_W-1:0] LUT_END  = 20'h00400,
    parameter logic [ADDR_W-1:0] RESET_PC = 20'h00400
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               stall_i,
    input  logic [2:0]         op_i,
    input  logic [SHORT_W-1:0] short_off_i,
    input  logic [LONG_W-1:0]  long_off_i,
    input  logic [ADDR_W-1:0]  reg_off_i,
    input  logic [ADDR_W-1:0]  abs_tgt_i,
    input  logic [LEN_W-1:0]   rep_len_i,
    input  logic [CNT_W-1:0]   rep_cnt_i,
    output logic [ADDR_W-1:0]  pc_o,
    output logic [1:0]         src_o,
    output logic               refill_o
);
    logic [ADDR_W-1:0] pc_q;
    logic              refill_q;
    ctx_e              cur_ctx;
    ctx_e              nxt_ctx;
    logic [ADDR_W-1:0] seq_a, short_a, long_a, regrel_a, rep_start;
    logic [ADDR_W-1:0] pc_d;
    logic              loop_hit;
    logic              flow;

    pcu_region #(.ADDR_W(ADDR_W), .REG_END(REG_END), .LUT_END(LUT_END)) u_cur_region (
        .addr_i (pc_q),
        .ctx_o  (cur_ctx)
    );

    pcu_region #(.ADDR_W(ADDR_W), .REG_END(REG_END), .LUT_END(LUT_END)) u_nxt_region (
        .addr_i (pc_d),
        .ctx_o  (nxt_ctx)
    );

    pcu_target #(.ADDR_W(ADDR_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W)) u_target (
        .pc_i        (pc_q),
        .ctx_i       (cur_ctx),
        .short_off_i (short_off_i),
        .long_off_i  (long_off_i),
        .reg_off_i   (reg_off_i),
        .seq_o       (seq_a),
        .short_o     (short_a),
        .long_o      (long_a),
        .regrel_o    (regrel_a)
    );

    pcu_repeat #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_repeat (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_i   (!stall_i),
        .op_i    (op_i),
        .pc_i    (pc_q),
        .seq_i   (seq_a),
        .shr_i   (cur_ctx == CTX_SHR),
        .len_i   (rep_len_i),
        .cnt_i   (rep_cnt_i),
        .hit_o   (loop_hit),
        .start_o (rep_start)
    );

    // Next-address select and change-of-flow flag.
    always_comb begin
        flow = 1'b1;
        case (op_i)
            OP_SHORT:  pc_d = short_a;
            OP_LONG:   pc_d = long_a;
            OP_REGREL: pc_d = regrel_a;
            OP_ABS:    pc_d = abs_tgt_i;
            OP_REP: begin
                pc_d = seq_a;
                flow = 1'b0;
            end
            default: begin
                pc_d = loop_hit ? rep_start : seq_a;
                flow = loop_hit;
            end
        endcase
    end

    // PC register and one-cycle refill request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q     <= RESET_PC;
            refill_q <= 1'b0;
        end else if (stall_i) begin
            refill_q <= 1'b0;
        end else begin
            pc_q     <= pc_d;
            refill_q <= flow && (nxt_ctx == CTX_SHR);
        end
    end

    assign pc_o     = pc_q;
    assign src_o    = cur_ctx;
    assign refill_o = refill_q;

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        stall_i |=> $stable(pc_o) && !refill_o); // R13
    AST_LOCAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i && op_i == OP_SEQ && !loop_hit && cur_ctx != CTX_SHR
        |=> pc_o == $past(pc_o) + ADDR_W'(1)); // R3
    AST_REFILL_IN_SHARED: assert property (@(posedge clk) disable iff (!rst_n)
        refill_o |-> pc_o >= LUT_END); // R12
    AST_LOCAL_LOOP_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i && loop_hit && cur_ctx != CTX_SHR |=> !refill_o); // R8
    AST_SHARED_LOOP_REFILL: assert property (@(posedge clk) disable iff (!rst_n)
        !stall_i && loop_hit && cur_ctx == CTX_SHR |=> refill_o); // R9
endmodule

// File: tb/sim_pc_unit.sv
module sim_pc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        stall_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [8:0]  short_off_i = '0;
    logic [19:0] long_off_i = '0;
    logic [19:0] reg_off_i = '0;
    logic [19:0] abs_tgt_i = '0;
    logic [8:0]  rep_len_i = '0;
    logic [8:0]  rep_cnt_i = '0;
    logic [19:0] pc_o;
    logic [1:0]  src_o;
    logic        refill_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    // Bench model state
    logic [19:0] m_pc = 20'h00400;
    logic [19:0] m_start = '0;
    logic [19:0] m_last = '0;
    logic [8:0]  m_rem = '0;

    always #5 clk = ~clk;

    pc_unit u0 (
        .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .op_i(op_i),
        .short_off_i(short_off_i), .long_off_i(long_off_i), .reg_off_i(reg_off_i),
        .abs_tgt_i(abs_tgt_i), .rep_len_i(rep_len_i), .rep_cnt_i(rep_cnt_i),
        .pc_o(pc_o), .src_o(src_o), .refill_o(refill_o)
    );

    function automatic logic [1:0] region_of(logic [19:0] a);
        if (a < 20'h00200) return 2'd0;
        if (a < 20'h00400) return 2'd1;
        return 2'd2;
    endfunction

    task automatic check(string tag, logic [19:0] act, logic [19:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one operation, advance the model, sample after the edge.
    task automatic do_op(logic [2:0] op, logic [8:0] sh = '0, logic [19:0] lg = '0,
                         logic [19:0] rg = '0, logic [19:0] ab = '0,
                         logic [8:0] ln = '0, logic [8:0] cn = '0,
                         bit stl = 0, string tag_ov = "");
        logic        shr;
        logic [19:0] stp, seqa, nxt, sp;
        logic        flow, hit;
        string       tag;
        stall_i = stl; op_i = op; short_off_i = sh; long_off_i = lg;
        reg_off_i = rg; abs_tgt_i = ab; rep_len_i = ln; rep_cnt_i = cn;
        shr  = (m_pc >= 20'h00400);
        stp  = shr ? 20'd4 : 20'd1;
        seqa = m_pc + stp;
        hit  = (m_rem != 0) && (m_pc == m_last) && (op == 0 || op > 5);
        flow = 1'b1;
        nxt  = seqa;
        tag  = "R3";
        if (stl) begin
            nxt = m_pc; flow = 1'b0; tag = "R13";
        end else begin
            case (op)
                3'd1: begin
                    nxt = seqa + (shr ? {{11{sh[8]}}, sh} << 2 : {{11{sh[8]}}, sh});
                    tag = "R4";
                end
                3'd2: begin
                    nxt = seqa + (shr ? lg : {{2{lg[19]}}, lg[19:2]});
                    tag = "R5";
                end
                3'd3: begin nxt = seqa + (shr ? rg << 2 : rg); tag = "R6"; end
                3'd4: begin nxt = ab; tag = "R7"; end
                3'd5: begin nxt = seqa; flow = 1'b0; tag = "R8"; end
                default: begin
                    nxt  = hit ? m_start : seqa;
                    flow = hit;
                    if (hit) tag = shr ? "R9" : "R8";
                end
            endcase
            if (op == 3'd5) begin
                sp = 20'(9'(ln - 9'd1));
                if (shr) sp = sp << 2;
                m_start = seqa;
                m_last  = seqa + sp;
                m_rem   = (ln != 0 && cn > 1) ? cn - 9'd1 : 9'd0;
            end else if (op >= 3'd1 && op <= 3'd4) begin
                m_rem = 0;
            end else if (hit) begin
                m_rem = m_rem - 9'd1;
            end
        end
        if (tag_ov != "") tag = tag_ov;
        @(negedge clk);
        check(tag, pc_o, nxt);
        check("R12", {19'd0, refill_o}, {19'd0, flow && nxt >= 20'h00400});
        check("R2", {18'd0, src_o}, {18'd0, region_of(nxt)});
        m_pc = nxt;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        r = $urandom(32'd4711);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1", pc_o, 20'h00400);
        check("R1", {19'd0, refill_o}, 20'd0);
        check("R2", {18'd0, src_o}, 20'd2);

        do_op(3'd0);                              // R3 shared step of 4
        do_op(3'd4, .ab(20'h001FF));              // R7 into register memory
        do_op(3'd0);                              // R2 boundary into lookup
        do_op(3'd4, .ab(20'h003FF));
        do_op(3'd0);                              // R2 boundary into shared, no refill
        do_op(3'd6);                              // R3 unused code advances
        // R4 short branches
        do_op(3'd4, .ab(20'h00100));
        do_op(3'd1, .sh(9'h100));                 // -256
        do_op(3'd4, .ab(20'h00100));
        do_op(3'd1, .sh(9'h0FF));                 // +255
        do_op(3'd4, .ab(20'h01000));
        do_op(3'd1, .sh(9'h1FF));                 // -1 instr in shared
        // R5 long branches
        do_op(3'd4, .ab(20'h00100));
        do_op(3'd2, .lg(20'hFFFF8));
        do_op(3'd4, .ab(20'h02000));
        do_op(3'd2, .lg(20'h00040));
        // R6 register-relative
        do_op(3'd4, .ab(20'h00050));
        do_op(3'd3, .rg(20'd3));
        do_op(3'd4, .ab(20'h03000));
        do_op(3'd3, .rg(20'd3));
        // R8 local repeat: 2 instructions, 3 passes
        do_op(3'd4, .ab(20'h00010));
        do_op(3'd5, .ln(9'd2), .cn(9'd3));
        repeat (5) do_op(3'd0);
        do_op(3'd0, .tag_ov("R10"));              // falls through after last pass
        // R9 shared repeat: 1 instruction, 2 passes
        do_op(3'd4, .ab(20'h00800));
        do_op(3'd5, .ln(9'd1), .cn(9'd2));
        do_op(3'd0);
        do_op(3'd0, .tag_ov("R10"));
        // R11 cancel by taken branch
        do_op(3'd4, .ab(20'h00020));
        do_op(3'd5, .ln(9'd3), .cn(9'd5));
        do_op(3'd0);
        do_op(3'd1, .sh(9'h000));
        do_op(3'd0, .tag_ov("R11"));
        // R10 zero length never loops
        do_op(3'd4, .ab(20'h00030));
        do_op(3'd5, .ln(9'd0), .cn(9'd4));
        repeat (3) do_op(3'd0, .tag_ov("R10"));
        // R13 stall holds
        do_op(3'd4, .ab(20'h00900), .stl(1));
        do_op(3'd1, .sh(9'h010), .stl(1));
        // R14 wrap
        do_op(3'd4, .ab(20'hFFFFC));
        do_op(3'd0, .tag_ov("R14"));
        do_op(3'd1, .sh(9'h1FF), .tag_ov("R14"));
        do_op(3'd4, .ab(20'hFFFFC));
        do_op(3'd2, .lg(20'h00008), .tag_ov("R14"));

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            logic [2:0]  op;
            logic [19:0] ab;
            r = $urandom;
            case (r % 12)
                0, 1, 2, 3, 4, 5: op = 3'd0;
                6: op = 3'd1;
                7: op = 3'd2;
                8: op = 3'd4;
                9: op = 3'd3;
                10: op = 3'd5;
                default: op = (r[8]) ? 3'd7 : 3'd6;
            endcase
            ab = $urandom;
            if (ab[0]) ab = ab & 20'h003FF;
            do_op(op, 9'($urandom), 20'($urandom), 20'($urandom % 64), ab,
                  9'($urandom % 5), 9'($urandom % 6), ($urandom % 10) == 0);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule